// File: doc/BRIEF.md
# Virtual-Channel Credit Link with Piggybacked Credit Return

This block keeps an upstream router from overrunning the input buffers of its downstream neighbour. The downstream input has several virtual channels, each with a fixed number of flit slots. The upstream end keeps one credit counter per virtual channel. Each counter starts at the slot count, drops by one for every flit it sends on that channel, and blocks further sends on that channel while it reads zero.

Returned credits do not use a wire of their own. Each time the downstream end frees a slot it raises a per-channel departure strobe. The freed slot is noted in a per-channel pending count. On every cycle at most one pending credit is attached to the flit going in the reverse direction, as a single valid bit plus a channel index. If the downstream side has a data flit to send, the credit rides on it. If not, the credit goes out on an idle flit that carries no data.

When several channels have credits waiting, a round-robin choice decides the order in which they go back. Credits for one channel are never dropped. Both ends and the two one-cycle link stages are inside the block, so the forward flit and the reverse flit are ports of this block.

Top module: `vc_credit_link`

## Requirements
- R1: After reset every channel's credit counter equals the buffer depth (default 4), so `vc_has_credit` is all ones, and `fwd_valid`, `rev_valid` and `rev_cred` are 0.
- R2: `tx_grant` is 1 exactly when `tx_req` is 1 and the channel `tx_vc` holds at least one credit. A request that is not granted puts nothing on the forward link.
- R3: A granted flit appears on `fwd_valid`/`fwd_vc`/`fwd_data` in the following cycle with the requested channel and unchanged data, and that channel's counter drops by one.
- R4: After depth grants on one channel with no credit returned, that channel's `vc_has_credit` bit is 0 and further requests on it are refused.
- R5: A counter never exceeds the depth. For every channel, credits plus downstream occupancy plus credits still on their way back plus flits still on the forward link equals the depth in every cycle.
- R6: A departure strobe sampled at one clock edge produces `rev_cred`=1 with `rev_cred_vc` naming that channel in the cycle after the next edge, when no other credit is waiting.
- R7: A reverse data request is presented on `rev_valid`/`rev_out_data` one cycle later, unchanged. When a credit is due in that cycle, the credit bit is set on that same data flit.
- R8: With no reverse data request, a due credit still goes out, on an idle flit (`rev_valid`=0, `rev_cred`=1).
- R9: Departures are counted per channel while they wait. Strobes on several channels in one cycle are all returned, one credit per reverse flit on successive cycles, and a credit is only returned for a channel that had a departure waiting.
- R10: Channels with waiting credits are served round-robin, starting with the channel after the one served last. After reset the search begins at channel 0.
- R11: A credit carried by a reverse flit becomes usable at the upstream counter in the next cycle, not in the same cycle.
- R12: Once traffic stops and all flits have departed, every counter is back at the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | Upstream wants to send a flit |
| tx_vc | input | VW | Virtual channel of that flit |
| tx_data | input | DW | Flit payload |
| tx_grant | output | 1 | Flit accepted this cycle |
| vc_has_credit | output | NVC | Per-channel nonzero-credit flags |
| fwd_valid | output | 1 | Forward link carries a flit |
| fwd_vc | output | VW | Channel of the forward flit |
| fwd_data | output | DW | Payload of the forward flit |
| dn_depart | input | NVC | Per-channel downstream buffer departure strobes |
| rev_req | input | 1 | Downstream has a reverse data flit |
| rev_data | input | DW | Reverse data payload |
| rev_valid | output | 1 | Reverse flit carries data (0 = idle flit) |
| rev_out_data | output | DW | Reverse flit payload |
| rev_cred | output | 1 | Piggybacked credit bit |
| rev_cred_vc | output | VW | Channel the credit belongs to |

## Verification
A short fixed pattern mixes sends, departures and reverse data, so that a grant, a credit return and a reverse data flit fall in the same cycle. This separates a correct net counter change from a lost increment or decrement. Long random traffic with stalls on all four channels checks the conservation sum on every cycle, which catches lost, duplicated or misrouted credits. Directed cases then cover the zero-credit stall, the exact return latency on idle and data flits, and a burst of four simultaneous departures whose return order shows round-robin service rather than fixed priority.

// File: rtl/credit_link_pkg.sv
`timescale 1ns/1ps
package credit_link_pkg;

    // Width of an index able to name n distinct values (minimum one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/crd_rr_pick.sv
`timescale 1ns/1ps
// Round-robin selector: first set request after the last served index.
module crd_rr_pick #(
    parameter int N  = 4,
    parameter int VW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [VW-1:0] last,
    output logic          any,
    output logic [VW-1:0] sel
);
    int idx;

    always_comb begin
        any = 1'b0;
        sel = last;
        idx = 0;
        for (int i = 1; i <= N; i++) begin
            idx = (int'(last) + i) % N;
            if (!any && req[idx]) begin
                any = 1'b1;
                sel = VW'(idx);
            end
        end
    end
endmodule

// File: rtl/crd_tx_side.sv
`timescale 1ns/1ps
// Upstream end: per-channel credit counters, send gating, forward link stage.
module crd_tx_side #(
    parameter int NVC   = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int VW    = credit_link_pkg::idx_width(NVC),
    parameter int CW    = credit_link_pkg::idx_width(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_req,
    input  logic [VW-1:0]            tx_vc,
    input  logic [DW-1:0]            tx_data,
    input  logic                     ret_valid,
    input  logic [VW-1:0]            ret_vc,
    output logic                     tx_grant,
    output logic [NVC-1:0]           vc_ready,
    output logic                     fwd_valid,
    output logic [VW-1:0]            fwd_vc,
    output logic [DW-1:0]            fwd_data,
    output logic [NVC-1:0][CW-1:0]   cnt_o
);
    typedef struct packed {
        logic [NVC-1:0][CW-1:0] cnt;
        logic                   fv;
        logic [VW-1:0]          fvc;
        logic [DW-1:0]          fdata;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      grant;

    always_comb begin
        st_d  = st_q;
        grant = tx_req && (st_q.cnt[tx_vc] != '0);
        for (int v = 0; v < NVC; v++) begin
            if ((grant && tx_vc == VW'(v)) && !(ret_valid && ret_vc == VW'(v))) begin
                st_d.cnt[v] = st_q.cnt[v] - CW'(1);
            end else if (!(grant && tx_vc == VW'(v)) && (ret_valid && ret_vc == VW'(v))) begin
                st_d.cnt[v] = st_q.cnt[v] + CW'(1);
            end
        end
        st_d.fv    = grant;
        st_d.fvc   = grant ? tx_vc   : st_q.fvc;
        st_d.fdata = grant ? tx_data : st_q.fdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NVC; v++) begin
                st_q.cnt[v] <= CW'(DEPTH);
            end
            st_q.fv    <= 1'b0;
            st_q.fvc   <= '0;
            st_q.fdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        for (int v = 0; v < NVC; v++) begin
            vc_ready[v] = (st_q.cnt[v] != '0);
        end
    end

    assign tx_grant  = grant;
    assign fwd_valid = st_q.fv;
    assign fwd_vc    = st_q.fvc;
    assign fwd_data  = st_q.fdata;
    assign cnt_o     = st_q.cnt;
endmodule

// File: rtl/crd_rx_side.sv
`timescale 1ns/1ps
// Downstream end: per-channel pending credits, round-robin pick,
// reverse link stage carrying data and one credit bit.
module crd_rx_side #(
    parameter int NVC   = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int VW    = credit_link_pkg::idx_width(NVC),
    parameter int CW    = credit_link_pkg::idx_width(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NVC-1:0]           depart,
    input  logic                     rev_req,
    input  logic [DW-1:0]            rev_data,
    output logic                     rev_valid,
    output logic [DW-1:0]            rev_out_data,
    output logic                     rev_cred,
    output logic [VW-1:0]            rev_cred_vc,
    output logic [NVC-1:0][CW-1:0]   pend_o
);
    typedef struct packed {
        logic [NVC-1:0][CW-1:0] pend;
        logic [VW-1:0]          last;
        logic                   rv;
        logic [DW-1:0]          rdata;
        logic                   rc;
        logic [VW-1:0]          rcvc;
    } rx_state_t;

    rx_state_t      st_d, st_q;
    logic [NVC-1:0] waiting;
    logic           pick_any;
    logic [VW-1:0]  pick_vc;

    always_comb begin
        for (int v = 0; v < NVC; v++) begin
            waiting[v] = (st_q.pend[v] != '0);
        end
    end

    crd_rr_pick #(.N(NVC), .VW(VW)) u_pick (
        .req  (waiting),
        .last (st_q.last),
        .any  (pick_any),
        .sel  (pick_vc)
    );

    always_comb begin
        st_d = st_q;
        for (int v = 0; v < NVC; v++) begin
            st_d.pend[v] = st_q.pend[v] + CW'(depart[v])
                         - CW'(pick_any && pick_vc == VW'(v));
        end
        st_d.last  = pick_any ? pick_vc : st_q.last;
        st_d.rc    = pick_any;
        st_d.rcvc  = pick_any ? pick_vc : st_q.rcvc;
        st_d.rv    = rev_req;
        st_d.rdata = rev_req ? rev_data : st_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.last  <= VW'(NVC - 1);
            st_q.rv    <= 1'b0;
            st_q.rdata <= '0;
            st_q.rc    <= 1'b0;
            st_q.rcvc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rev_valid    = st_q.rv;
    assign rev_out_data = st_q.rdata;
    assign rev_cred     = st_q.rc;
    assign rev_cred_vc  = st_q.rcvc;
    assign pend_o       = st_q.pend;
endmodule

// File: rtl/vc_credit_link.sv
`timescale 1ns/1ps
module vc_credit_link #(
    parameter int NVC   = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int VW    = credit_link_pkg::idx_width(NVC),
    parameter int CW    = credit_link_pkg::idx_width(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_req,
    input  logic [VW-1:0]   tx_vc,
    input  logic [DW-1:0]   tx_data,
    output logic            tx_grant,
    output logic [NVC-1:0]  vc_has_credit,
    output logic            fwd_valid,
    output logic [VW-1:0]   fwd_vc,
    output logic [DW-1:0]   fwd_data,
    input  logic [NVC-1:0]  dn_depart,
    input  logic            rev_req,
    input  logic [DW-1:0]   rev_data,
    output logic            rev_valid,
    output logic [DW-1:0]   rev_out_data,
    output logic            rev_cred,
    output logic [VW-1:0]   rev_cred_vc
);
    logic [NVC-1:0][CW-1:0] crd_cnt;
    logic [NVC-1:0][CW-1:0] pend_cnt;

    crd_tx_side #(.NVC(NVC), .DEPTH(DEPTH), .DW(DW), .VW(VW), .CW(CW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_req    (tx_req),
        .tx_vc     (tx_vc),
        .tx_data   (tx_data),
        .ret_valid (rev_cred),
        .ret_vc    (rev_cred_vc),
        .tx_grant  (tx_grant),
        .vc_ready  (vc_has_credit),
        .fwd_valid (fwd_valid),
        .fwd_vc    (fwd_vc),
        .fwd_data  (fwd_data),
        .cnt_o     (crd_cnt)
    );

    crd_rx_side #(.NVC(NVC), .DEPTH(DEPTH), .DW(DW), .VW(VW), .CW(CW)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .depart       (dn_depart),
        .rev_req      (rev_req),
        .rev_data     (rev_data),
        .rev_valid    (rev_valid),
        .rev_out_data (rev_out_data),
        .rev_cred     (rev_cred),
        .rev_cred_vc  (rev_cred_vc),
        .pend_o       (pend_cnt)
    );
endmodule

// File: rtl/vc_credit_link_chk.sv
`timescale 1ns/1ps
module vc_credit_link_chk #(
    parameter int NVC   = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int VW    = 2,
    parameter int CW    = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tx_req,
    input logic [VW-1:0]          tx_vc,
    input logic [DW-1:0]          tx_data,
    input logic                   tx_grant,
    input logic [NVC-1:0]         vc_has_credit,
    input logic                   fwd_valid,
    input logic [VW-1:0]          fwd_vc,
    input logic [DW-1:0]          fwd_data,
    input logic                   rev_req,
    input logic [DW-1:0]          rev_data,
    input logic                   rev_valid,
    input logic [DW-1:0]          rev_out_data,
    input logic                   rev_cred,
    input logic [VW-1:0]          rev_cred_vc,
    input logic [NVC-1:0][CW-1:0] crd_cnt,
    input logic [NVC-1:0][CW-1:0] pend_cnt
);
    assert_fwd_follows_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> (fwd_valid && fwd_vc == $past(tx_vc) && fwd_data == $past(tx_data)));

    assert_silent_when_refused_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_grant |=> !fwd_valid);

    assert_stall_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !vc_has_credit[tx_vc]) |-> !tx_grant);

    assert_rev_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rev_req |=> (rev_valid && rev_out_data == $past(rev_data)));

    assert_idle_flit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_req |=> !rev_valid);

    assert_credit_usable_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_cred && !(tx_grant && tx_vc == rev_cred_vc))
        |=> (crd_cnt[$past(rev_cred_vc)] == $past(crd_cnt[rev_cred_vc]) + CW'(1)));

    for (genvar v = 0; v < NVC; v++) begin : g_vc
        assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            crd_cnt[v] <= CW'(DEPTH));

        assert_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(crd_cnt[v]) + int'(pend_cnt[v])
             + int'(rev_cred && rev_cred_vc == VW'(v))) <= DEPTH);
    end
endmodule

bind vc_credit_link vc_credit_link_chk #(
    .NVC(NVC), .DEPTH(DEPTH), .DW(DW), .VW(VW), .CW(CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_req        (tx_req),
    .tx_vc         (tx_vc),
    .tx_data       (tx_data),
    .tx_grant      (tx_grant),
    .vc_has_credit (vc_has_credit),
    .fwd_valid     (fwd_valid),
    .fwd_vc        (fwd_vc),
    .fwd_data      (fwd_data),
    .rev_req       (rev_req),
    .rev_data      (rev_data),
    .rev_valid     (rev_valid),
    .rev_out_data  (rev_out_data),
    .rev_cred      (rev_cred),
    .rev_cred_vc   (rev_cred_vc),
    .crd_cnt       (crd_cnt),
    .pend_cnt      (pend_cnt)
);

// File: tb/sim_vc_credit_link.sv
`timescale 1ns/1ps
module sim_vc_credit_link;
    localparam int NVC   = 4;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int VW    = 2;
    localparam int NVEC  = 16;

    // vector: [7] req, [6:5] vc, [4:1] departure mask, [0] reverse data request
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_00_0000_0, 8'b1_00_0000_1, 8'b1_01_0000_0, 8'b1_00_0000_0,
        8'b1_00_0001_1, 8'b1_00_0000_0, 8'b1_00_0011_1, 8'b0_00_0001_0,
        8'b1_11_0001_1, 8'b1_01_0010_0, 8'b1_00_0001_0, 8'b0_00_0000_1,
        8'b1_10_1000_0, 8'b1_00_0011_1, 8'b1_11_0000_1, 8'b0_00_1111_0
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tx_req;
    logic [VW-1:0]  tx_vc;
    logic [DW-1:0]  tx_data;
    logic           tx_grant;
    logic [NVC-1:0] vc_has_credit;
    logic           fwd_valid;
    logic [VW-1:0]  fwd_vc;
    logic [DW-1:0]  fwd_data;
    logic [NVC-1:0] dn_depart;
    logic           rev_req;
    logic [DW-1:0]  rev_data;
    logic           rev_valid;
    logic [DW-1:0]  rev_out_data;
    logic           rev_cred;
    logic [VW-1:0]  rev_cred_vc;

    always #2 clk = ~clk;

    vc_credit_link #(.NVC(NVC), .DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_vc(tx_vc), .tx_data(tx_data),
        .tx_grant(tx_grant), .vc_has_credit(vc_has_credit), .fwd_valid(fwd_valid),
        .fwd_vc(fwd_vc), .fwd_data(fwd_data), .dn_depart(dn_depart), .rev_req(rev_req),
        .rev_data(rev_data), .rev_valid(rev_valid), .rev_out_data(rev_out_data),
        .rev_cred(rev_cred), .rev_cred_vc(rev_cred_vc)
    );

    int n_chk = 0;
    int n_bad = 0;
    int mcred [NVC];
    int occ   [NVC];
    int pend  [NVC];
    int last_rr = NVC - 1;
    int seq = 0;
    logic          exp_fwd = 1'b0;
    logic [VW-1:0] exp_fvc = '0;
    logic [DW-1:0] exp_fdata = '0;
    logic          exp_rv = 1'b0;
    logic [DW-1:0] exp_rdata = '0;
    logic           s_grant, s_rc, s_rv;
    logic [VW-1:0]  s_rcvc;
    logic [NVC-1:0] s_ready;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit req, input int vc, input logic [NVC-1:0] dep, input bit rreq);
        logic [NVC-1:0] d;
        bit eg;
        @(negedge clk);
        for (int v = 0; v < NVC; v++) d[v] = dep[v] && (occ[v] > 0);
        seq++;
        tx_req    = req;
        tx_vc     = VW'(vc);
        tx_data   = DW'(seq * 7 + 3);
        dn_depart = d;
        rev_req   = rreq;
        rev_data  = DW'(seq * 13 + 5);
        #1;
        s_grant = tx_grant; s_rc = rev_cred; s_rcvc = rev_cred_vc;
        s_rv = rev_valid; s_ready = vc_has_credit;
        eg = req && (mcred[vc] > 0);
        check(tx_grant == eg, "R2 grant", int'(tx_grant), int'(eg));
        check(fwd_valid == exp_fwd, "R3 fwd_valid", int'(fwd_valid), int'(exp_fwd));
        if (exp_fwd) begin
            check(fwd_vc == exp_fvc, "R3 fwd_vc", int'(fwd_vc), int'(exp_fvc));
            check(fwd_data == exp_fdata, "R3 fwd_data", int'(fwd_data), int'(exp_fdata));
        end
        check(rev_valid == exp_rv, "R7 R8 rev_valid", int'(rev_valid), int'(exp_rv));
        if (exp_rv) check(rev_out_data == exp_rdata, "R7 rev_data", int'(rev_out_data), int'(exp_rdata));
        if (rev_cred) check(pend[rev_cred_vc] > 0, "R9 credit without departure", pend[rev_cred_vc], 1);
        for (int v = 0; v < NVC; v++) begin
            int sum;
            sum = mcred[v] + occ[v] + pend[v] + int'(fwd_valid && fwd_vc == VW'(v));
            check(sum == DEPTH, "R5 conservation", sum, DEPTH);
            check(mcred[v] <= DEPTH, "R5 overflow", mcred[v], DEPTH);
            check(vc_has_credit[v] == (mcred[v] > 0), "R4 credit flag",
                  int'(vc_has_credit[v]), int'(mcred[v] > 0));
        end
        exp_fwd   = tx_grant;
        exp_fvc   = tx_vc;
        exp_fdata = tx_data;
        exp_rv    = rreq;
        exp_rdata = rev_data;
        if (tx_grant) mcred[vc]--;
        if (rev_cred) begin
            mcred[rev_cred_vc]++;
            pend[rev_cred_vc]--;
            last_rr = int'(rev_cred_vc);
        end
        if (fwd_valid) occ[fwd_vc]++;
        for (int v = 0; v < NVC; v++) begin
            if (d[v]) begin
                occ[v]--;
                pend[v]++;
            end
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 60; k++) begin
            bit busy;
            busy = exp_fwd;
            for (int v = 0; v < NVC; v++) if (occ[v] > 0 || pend[v] > 0) busy = 1'b1;
            if (!busy) break;
            step(1'b0, 0, 4'b1111, 1'b0);
        end
        step(1'b0, 0, 4'b0000, 1'b0);
        for (int v = 0; v < NVC; v++) begin
            check(mcred[v] == DEPTH, "R12 refilled", mcred[v], DEPTH);
            check(s_ready[v] == 1'b1, "R12 credit flag", int'(s_ready[v]), 1);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        for (int v = 0; v < NVC; v++) begin
            mcred[v] = DEPTH; occ[v] = 0; pend[v] = 0;
        end
        rst_n = 1'b0; tx_req = 1'b0; tx_vc = '0; tx_data = '0;
        dn_depart = '0; rev_req = 1'b0; rev_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(vc_has_credit == 4'hF, "R1 credit flags", int'(vc_has_credit), 15);
        check(!fwd_valid, "R1 fwd_valid", int'(fwd_valid), 0);
        check(!rev_valid, "R1 rev_valid", int'(rev_valid), 0);
        check(!rev_cred, "R1 rev_cred", int'(rev_cred), 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][7], int'(VEC[i][6:5]), VEC[i][4:1], VEC[i][0]);
        end
        drain();

        // random traffic with stalls
        for (int i = 0; i < 3000; i++) begin
            logic [NVC-1:0] dm;
            dm = NVC'($urandom & $urandom);
            step(($urandom % 4) != 0, int'($urandom % NVC), dm, ($urandom % 2) == 0);
        end
        drain();

        // R4: exhaust channel 2
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 2, 4'b0000, 1'b0);
            check(s_grant == 1'b1, "R4 grant while credits remain", int'(s_grant), 1);
        end
        step(1'b1, 2, 4'b0000, 1'b0);
        check(s_grant == 1'b0, "R4 refused at zero", int'(s_grant), 0);
        check(s_ready[2] == 1'b0, "R4 flag at zero", int'(s_ready[2]), 0);
        step(1'b0, 0, 4'b0000, 1'b0);

        // R6, R8, R11: single departure on an idle reverse link
        step(1'b0, 0, 4'b0100, 1'b0);
        step(1'b0, 0, 4'b0000, 1'b0);
        check(s_rc == 1'b0, "R6 not early", int'(s_rc), 0);
        step(1'b1, 2, 4'b0000, 1'b0);
        check(s_rc == 1'b1, "R6 credit returned", int'(s_rc), 1);
        check(s_rcvc == 2'd2, "R6 credit channel", int'(s_rcvc), 2);
        check(s_rv == 1'b0, "R8 idle flit", int'(s_rv), 0);
        check(s_grant == 1'b0, "R11 not same cycle", int'(s_grant), 0);
        step(1'b1, 2, 4'b0000, 1'b0);
        check(s_grant == 1'b1, "R11 usable next cycle", int'(s_grant), 1);

        // R7: credit piggybacked on a data flit
        step(1'b0, 0, 4'b0100, 1'b0);
        step(1'b0, 0, 4'b0000, 1'b1);
        step(1'b0, 0, 4'b0000, 1'b0);
        check(s_rc == 1'b1 && s_rv == 1'b1, "R7 credit with data",
              int'({s_rc, s_rv}), 3);
        drain();

        // R9, R10: four departures in one cycle
        step(1'b1, 3, 4'b0000, 1'b0);
        step(1'b1, 1, 4'b0000, 1'b0);
        step(1'b1, 0, 4'b0000, 1'b0);
        step(1'b1, 2, 4'b0000, 1'b0);
        step(1'b0, 0, 4'b0000, 1'b0);
        step(1'b0, 0, 4'b1111, 1'b0);
        base = last_rr;
        step(1'b0, 0, 4'b0000, 1'b0);
        for (int k = 1; k <= NVC; k++) begin
            step(1'b0, 0, 4'b0000, 1'b0);
            check(s_rc == 1'b1, "R9 burst credit present", int'(s_rc), 1);
            check(int'(s_rcvc) == (base + k) % NVC, "R10 round-robin order",
                  int'(s_rcvc), (base + k) % NVC);
        end
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule